// File: doc/BRIEF.md
# Mode-Based Register Access Unit

This unit sits on the bus side of an interrupt distributor, in front of its 32-bit backing registers. Each access carries an address, a size in bytes, a write flag and write data. A small range table decodes the address into a region and a byte offset inside that region. The decode is combinational, so the caller can look up the addressed backing word and return it on `cur_value` in the same cycle. Each region has a read mode and a write mode. The unit applies those modes to the byte lanes that the access covers. One cycle later it returns the read data, and on writes it returns the new register value for the caller to store.

The write modes are ignore, set-bits, clear-bits and full write. The read modes are value and read-as-zero. An access wider than four bytes gets an abort response. An access that falls in no region gets a zero response and is flagged as unhandled. The enable-clear region has one extra rule: after any write to its first word, the sixteen software-interrupt enable bits are forced back to 1.

Top module: `mode_reg_access`

## Requirements
- R1: Read modes use one bit per region. A value-mode region returns register data on a read. A read-as-zero region returns 0.
- R2: Read data equals `cur_value` shifted right by 8 × (addr[1:0]) and then masked to size×8 low bits. A size of 4 or more keeps all 32 bits. Read data is 0 on a write.
- R3: Write mode 1 (set-bits) ORs the lane-aligned, size-masked write data into `cur_value`.
- R4: Write mode 2 (clear-bits) clears in `cur_value` every bit that is 1 in the lane-aligned, size-masked write data.
- R5: Write mode 3 (full write) replaces only the addressed bytes with the size-masked write data and keeps every other byte of `cur_value`.
- R6: Write mode 0 (ignore) never raises `upd_en`.
- R7: A size greater than 4 gives `resp_abort`=1, `resp_rdata`=0, `upd_en`=0 and `resp_miss`=0.
- R8: A region matches only when base ≤ addr and addr+size ≤ base+length. When regions overlap, the lowest index wins. `hit_offset` is addr−base. The decode does not depend on size legality or on `req_valid`.
- R9: An access of legal size that matches no region gives `resp_miss`=1, `resp_rdata`=0 and `upd_en`=0.
- R10: A write to region 3 at an offset below 4 returns `upd_value[15:0]`=16'hFFFF after the clear has been applied. Writes to other offsets of that region are not forced.
- R11: After reset all outputs are 0. Every response and update appears in the cycle after the request edge. `resp_valid` follows `req_valid` one cycle later.
- R12: With the default parameters, region k sits at base k×0x100. Regions 0–6 have lengths 12, 8, 8, 8, 8, 8, 64. Their (read, write) modes are (1,3), (0,0), (1,1), (1,2), (1,1), (1,2), (1,3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_addr | input | ADDR_W | Byte address within the distributor window |
| req_size | input | 4 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-aligned |
| cur_value | input | 32 | Backing word for the decoded region and offset |
| hit_valid | output | 1 | Combinational: address lies inside a region |
| hit_region | output | REG_W | Combinational: matched region index |
| hit_offset | output | ADDR_W | Combinational: byte offset inside the region |
| resp_valid | output | 1 | Registered response strobe |
| resp_rdata | output | 32 | Registered read data |
| resp_abort | output | 1 | Registered: access was too wide |
| resp_miss | output | 1 | Registered: no region matched |
| upd_en | output | 1 | Registered: caller must store `upd_value` |
| upd_region | output | REG_W | Region of the update |
| upd_offset | output | ADDR_W | Byte offset of the update |
| upd_value | output | 32 | New register value |

## Verification
Some checks run every cycle as assertions. They cover the read-as-zero rule, that ignore mode leaves the word untouched, and that bytes outside the addressed lanes are never altered. They also cover that matched accesses lie wholly inside their region, that aborts and misses never update, the forced enable bits, and the one-cycle response timing. Other behaviour can only be shown by the bench's scenarios, run against a byte-by-byte model. These are the exact merged values for each write mode at unaligned lanes and the lowest-index priority among regions. The bench also covers accesses that straddle a region end, the boundary between the first and second word of the enable-clear region, and a long run of mixed random accesses.

// File: rtl/mra_pkg.sv
package mra_pkg;

  typedef enum logic [1:0] {
    WR_IGNORE = 2'd0,
    WR_SET    = 2'd1,
    WR_CLEAR  = 2'd2,
    WR_FULL   = 2'd3
  } wr_mode_e;

  typedef struct packed {
    logic [15:0] len;
    logic        rd_val;
    wr_mode_e    wr;
    logic        force_low;
  } region_t;

  localparam int NUM_REGIONS = 7;
  localparam int REG_W       = $clog2(NUM_REGIONS);

  // Region table: lengths scale with the interrupt count.
  function automatic region_t region_cfg(input int idx, input int nirq);
    region_t r;
    r = '{len: 16'(nirq / 8), rd_val: 1'b1, wr: WR_IGNORE, force_low: 1'b0};
    case (idx)
      0: begin r.len = 16'd12; r.wr = WR_FULL; end
      1: begin r.rd_val = 1'b0; r.wr = WR_IGNORE; end
      2: r.wr = WR_SET;
      3: begin r.wr = WR_CLEAR; r.force_low = 1'b1; end
      4: r.wr = WR_SET;
      5: r.wr = WR_CLEAR;
      default: begin r.len = 16'(nirq); r.wr = WR_FULL; end
    endcase
    return r;
  endfunction

  function automatic logic [31:0] size_mask(input logic [3:0] sz);
    case (sz)
      4'd0:    return 32'h0000_0000;
      4'd1:    return 32'h0000_00FF;
      4'd2:    return 32'h0000_FFFF;
      4'd3:    return 32'h00FF_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] lane_bits(input logic [1:0] lo, input logic [3:0] sz);
    return size_mask(sz) << {lo, 3'b000};
  endfunction

  function automatic logic [31:0] lane_read(input logic [31:0] cur, input logic [1:0] lo,
                                            input logic [3:0] sz);
    return (cur >> {lo, 3'b000}) & size_mask(sz);
  endfunction

  function automatic logic [31:0] lane_write(input logic [31:0] cur, input logic [31:0] wdata,
                                             input logic [1:0] lo, input logic [3:0] sz,
                                             input wr_mode_e mode);
    logic [31:0] d;
    logic [31:0] m;
    d = (wdata & size_mask(sz)) << {lo, 3'b000};
    m = lane_bits(lo, sz);
    case (mode)
      WR_SET:   return cur | d;
      WR_CLEAR: return cur & ~d;
      WR_FULL:  return (cur & ~m) | d;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/mra_decode.sv
module mra_decode
  import mra_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NIRQ   = 64,
  parameter int STRIDE = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  output logic              hit,
  output logic [REG_W-1:0]  region,
  output logic [ADDR_W-1:0] offset
);

  logic [NUM_REGIONS-1:0] match;
  logic [31:0]            a_ext;
  logic [31:0]            end_ext;

  assign a_ext   = 32'(addr);
  assign end_ext = a_ext + 32'(size);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rng
    localparam region_t     CFG = region_cfg(g, NIRQ);
    localparam logic [31:0] LO  = 32'(g * STRIDE);
    localparam logic [31:0] HI  = LO + 32'(CFG.len);
    assign match[g] = (a_ext >= LO) && (end_ext <= HI);
  end

  always_comb begin
    hit    = 1'b0;
    region = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit    = 1'b1;
        region = REG_W'(i);
      end
    end
    offset = addr - ADDR_W'(32'(region) * 32'(STRIDE));
  end

  // R8: a reported hit lies wholly inside the chosen region
  p_inside_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (32'(offset) + 32'(size) <= 32'(region_cfg(int'(region), NIRQ).len)));

endmodule

// File: rtl/mra_lane.sv
module mra_lane
  import mra_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        active,
  input  logic [31:0] cur,
  input  logic [31:0] wdata,
  input  logic [1:0]  lo,
  input  logic [3:0]  size,
  input  logic        rd_val,
  input  wr_mode_e    wmode,
  input  logic        force_low,
  output logic [31:0] rdata,
  output logic [31:0] next_val,
  output logic [31:0] lanes
);

  logic [31:0] merged;

  assign lanes    = lane_bits(lo, size);
  assign rdata    = rd_val ? lane_read(cur, lo, size) : 32'h0;
  assign merged   = lane_write(cur, wdata, lo, size, wmode);
  assign next_val = force_low ? {merged[31:16], 16'hFFFF} : merged;

  // R1: read-as-zero regions never return data
  p_raz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !rd_val) |-> (rdata == 32'h0));

  // R5: bytes outside the addressed lanes are preserved by any write mode
  p_lanes_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !force_low) |-> (((next_val ^ cur) & ~lanes) == 32'h0));

  // R6: ignore mode leaves the word as it was
  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wmode == WR_IGNORE && !force_low) |-> (next_val == cur));

endmodule

// File: rtl/mode_reg_access.sv
module mode_reg_access
  import mra_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NIRQ   = 64,
  parameter int STRIDE = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  input  logic [31:0]       cur_value,
  output logic              hit_valid,
  output logic [REG_W-1:0]  hit_region,
  output logic [ADDR_W-1:0] hit_offset,
  output logic              resp_valid,
  output logic [31:0]       resp_rdata,
  output logic              resp_abort,
  output logic              resp_miss,
  output logic              upd_en,
  output logic [REG_W-1:0]  upd_region,
  output logic [ADDR_W-1:0] upd_offset,
  output logic [31:0]       upd_value
);

  localparam int FORCE_REGION = 3;

  region_t     cfg;
  logic        too_wide;
  logic        first_word;
  logic        do_force;
  logic        lane_active;
  logic [31:0] lane_rdata;
  logic [31:0] lane_next;
  logic [31:0] lane_mask;
  logic        upd_d;
  logic        miss_d;
  logic [31:0] rdata_d;

  mra_decode #(.ADDR_W(ADDR_W), .NIRQ(NIRQ), .STRIDE(STRIDE)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (req_addr),
    .size   (req_size),
    .hit    (hit_valid),
    .region (hit_region),
    .offset (hit_offset)
  );

  assign cfg         = region_cfg(int'(hit_region), NIRQ);
  assign too_wide    = req_size > 4'd4;
  assign first_word  = hit_offset < ADDR_W'(4);
  assign do_force    = cfg.force_low && first_word && req_write;
  assign lane_active = req_valid && hit_valid && !too_wide;

  mra_lane u_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (lane_active),
    .cur       (cur_value),
    .wdata     (req_wdata),
    .lo        (req_addr[1:0]),
    .size      (req_size),
    .rd_val    (cfg.rd_val),
    .wmode     (cfg.wr),
    .force_low (do_force),
    .rdata     (lane_rdata),
    .next_val  (lane_next),
    .lanes     (lane_mask)
  );

  assign upd_d   = lane_active && req_write && (cfg.wr != WR_IGNORE);
  assign miss_d  = req_valid && !too_wide && !hit_valid;
  assign rdata_d = (lane_active && !req_write) ? lane_rdata : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      resp_abort <= 1'b0;
      resp_miss  <= 1'b0;
      upd_en     <= 1'b0;
      upd_region <= '0;
      upd_offset <= '0;
      upd_value  <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_rdata <= rdata_d;
      resp_abort <= req_valid && too_wide;
      resp_miss  <= miss_d;
      upd_en     <= upd_d;
      upd_region <= hit_region;
      upd_offset <= hit_offset;
      upd_value  <= upd_d ? lane_next : 32'h0;
    end
  end

  // R7: an abort never updates, misses or returns data
  p_abort_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_abort |-> (!upd_en && !resp_miss && resp_rdata == 32'h0));

  // R9: an unmatched access is inert
  p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_miss |-> (!upd_en && resp_rdata == 32'h0));

  // R10: first word of the enable-clear region keeps its low 16 bits set
  p_force_sgi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_region == REG_W'(FORCE_REGION) && upd_offset < ADDR_W'(4))
      |-> (upd_value[15:0] == 16'hFFFF));

  // R11: response strobe trails the request by exactly one cycle
  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid == $past(req_valid));

  // R11: nothing is reported without a request
  p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> (!upd_en && !resp_abort && !resp_miss));

endmodule

// File: tb/mode_reg_access_bench.sv
module mode_reg_access_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [31:0] cur_value = '0;
  logic        hit_valid;
  logic [2:0]  hit_region;
  logic [11:0] hit_offset;
  logic        resp_valid, resp_abort, resp_miss, upd_en;
  logic [31:0] resp_rdata, upd_value;
  logic [2:0]  upd_region;
  logic [11:0] upd_offset;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  mode_reg_access u_mode_reg_access (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .cur_value(cur_value), .hit_valid(hit_valid), .hit_region(hit_region),
    .hit_offset(hit_offset), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .resp_abort(resp_abort), .resp_miss(resp_miss), .upd_en(upd_en),
    .upd_region(upd_region), .upd_offset(upd_offset), .upd_value(upd_value)
  );

  int lens[7] = '{12, 8, 8, 8, 8, 8, 64};
  int rdv[7]  = '{1, 0, 1, 1, 1, 1, 1};
  int wmd[7]  = '{3, 0, 1, 2, 1, 2, 3};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [11:0] a, input int sz, input bit wr,
                       input logic [31:0] wd, input logic [31:0] cur, input string tag);
    bit          e_hit, e_abort, e_miss, e_upd;
    int          e_reg, lo, b;
    logic [11:0] e_off;
    logic [31:0] e_rd, e_nv;
    logic [7:0]  d;
    e_hit = 0; e_reg = 0; e_off = '0;
    for (int k = 6; k >= 0; k--)
      if (int'(a) >= k * 256 && int'(a) + sz <= k * 256 + lens[k]) begin
        e_hit = 1; e_reg = k; e_off = 12'(int'(a) - k * 256);
      end
    e_abort = sz > 4;
    e_miss  = !e_abort && !e_hit;
    lo      = int'(a[1:0]);
    e_rd    = '0;
    if (!wr && e_hit && !e_abort && rdv[e_reg] == 1)
      for (int j = 0; j < 4; j++)
        if (j < sz && lo + j < 4) e_rd[8*j +: 8] = cur[8*(lo+j) +: 8];
    e_nv = cur;
    for (b = 0; b < 4; b++)
      if (b >= lo && b - lo < sz) begin
        d = wd[8*(b-lo) +: 8];
        case (wmd[e_reg])
          1: e_nv[8*b +: 8] = cur[8*b +: 8] | d;
          2: e_nv[8*b +: 8] = cur[8*b +: 8] & ~d;
          3: e_nv[8*b +: 8] = d;
          default: ;
        endcase
      end
    if (e_reg == 3 && e_off < 4) e_nv[15:0] = 16'hFFFF;
    e_upd = wr && e_hit && !e_abort && wmd[e_reg] != 0;

    @(negedge clk);
    req_valid = 1; req_addr = a; req_size = 4'(sz); req_write = wr;
    req_wdata = wd; cur_value = cur;
    #1;
    check({"R8 hit ", tag}, 32'(hit_valid), 32'(e_hit));
    if (e_hit) begin
      check({"R8 region ", tag}, 32'(hit_region), 32'(e_reg));
      check({"R8 offset ", tag}, 32'(hit_offset), 32'(e_off));
    end
    @(negedge clk);
    req_valid = 0;
    check({"R11 valid ", tag}, 32'(resp_valid), 32'd1);
    check({"R7 abort ", tag}, 32'(resp_abort), 32'(e_abort));
    check({"R9 miss ", tag}, 32'(resp_miss), 32'(e_miss));
    check({"R2 rdata ", tag}, resp_rdata, e_rd);
    check({"R6 upd_en ", tag}, 32'(upd_en), 32'(e_upd));
    if (e_upd) begin
      check({"R5 upd_value ", tag}, upd_value, e_nv);
      check({"R12 upd_region ", tag}, 32'(upd_region), 32'(e_reg));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset resp_valid", 32'(resp_valid), 32'd0);
    check("R11 reset upd_en", 32'(upd_en), 32'd0);
    check("R11 reset rdata", resp_rdata, 32'd0);
    rst_n = 1;
    apply(12'h000, 4, 0, 32'h0, 32'hA5A5_1234, "R1 full read");
    apply(12'h001, 1, 0, 32'h0, 32'hA5A5_1234, "R2 byte1 read");
    apply(12'h002, 2, 0, 32'h0, 32'hA5A5_1234, "R2 half read");
    apply(12'h100, 4, 0, 32'h0, 32'hFFFF_FFFF, "R1 raz read");
    apply(12'h201, 1, 1, 32'h80, 32'h0000_0001, "R3 set byte1");
    apply(12'h500, 4, 1, 32'h0F0F, 32'hFFFF_FFFF, "R4 clear word");
    apply(12'h602, 2, 1, 32'hBEEF, 32'h1122_3344, "R5 full half");
    apply(12'h603, 1, 1, 32'hFFAB, 32'h1122_3344, "R5 full byte3");
    apply(12'h104, 4, 1, 32'hFFFF_FFFF, 32'h0, "R6 ignore write");
    apply(12'h000, 8, 0, 32'h0, 32'hFFFF_FFFF, "R7 wide read");
    apply(12'h200, 5, 1, 32'hFF, 32'h0, "R7 wide write");
    apply(12'h00A, 4, 0, 32'h0, 32'h1, "R9 straddle end");
    apply(12'h7F0, 4, 0, 32'h0, 32'h1, "R9 outside table");
    apply(12'h300, 4, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 first word");
    apply(12'h304, 4, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 second word");
    apply(12'h302, 1, 1, 32'h01, 32'h00FF_0000, "R10 byte in first word");
    apply(12'h63F, 1, 0, 32'h0, 32'h7700_0000, "R8 last byte");
    for (int i = 0; i < 300; i++)
      apply(12'($urandom_range(0, 12'h7FF)), int'($urandom_range(1, 6)),
            1'($urandom), $urandom, $urandom, "R12 random");
    @(negedge clk);
    check("R11 idle resp_valid", 32'(resp_valid), 32'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL R11 watchdog: actual hung expected done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule